// File: doc/BRIEF.md
# Configuration Port Ownership Controller

This block lets a host take over and later hand back a device configuration port. It also lets the host pulse the device's configuration reset while it holds the port. Requests arrive as single-cycle pulses: take ownership, release ownership, assert reset and release reset. A take-ownership request also carries a requested mode: a bus width of 16 or 32 bits, encryption on or off, and compression on or off.

The block samples the mode-select strap and the external levels of the nCONFIG and nSTATUS pins. From these it steps the port's drive and override outputs through a fixed, safe order. It also sets the width and clock-to-data ratio fields. Each accepted request ends with a one-cycle done pulse and a result code. Moving the configuration data and running the full configuration sequence belong to other blocks.

Top module: `cfgport_owner_ctrl`

## Requirements
- R1: After reset: chip enable (active low) is driven high, nCONFIG drive is high, every override and both path enables are low, width is 16, ratio code is 0, and owned, busy, done are low with result code 0.
- R2: A take-ownership request while not owned fails with result 1 unless the 3-bit strap reads 000 or 001. The port outputs stay as they were and done appears 2 cycles after the request edge.
- R3: With a good strap, if the nCONFIG pin or the nSTATUS pin reads low at the first check, the request fails with result 2. Ownership is not taken.
- R4: With a good strap, the width output becomes 1 for 32-bit mode and 0 for 16-bit mode. The ratio code is log2 of the clock-to-data ratio: 1 with neither encryption nor compression. With compression on, the ratio is 4 at 16 bits and 8 at 32 bits. With encryption only, it is 2 at 16 bits and 4 at 32 bits.
- R5: Takeover runs one step per cycle in this order: safe state (chip enable high, nCONFIG high, path enables low, status and done overrides off); then the data/clock and nCONFIG overrides on; then chip enable low; then a recheck of both pins. On success, owned rises with done and result 0, 6 sampling cycles after the request.
- R6: If either pin reads low at the recheck, the request ends with result 3. Chip enable returns high, the overrides turn off and owned stays low.
- R7: A take-ownership request while already owned completes at once with result 0 and changes no output.
- R8: Release while owned clears owned at once. It first drives nCONFIG high if a reset is held, then drives chip enable high, then turns the overrides off, and ends with result 0. Release while not owned completes at once with result 0.
- R9: Reset assert drives nCONFIG low and polls nSTATUS until it reads low. Reset release drives nCONFIG high and polls until nSTATUS reads high. After POLL_LIMIT polls without success the request ends with result 5, and the nCONFIG level it set is kept.
- R10: A reset request while not owned ends at once with result 4 and leaves nCONFIG high.
- R11: A reset assert while a reset is already held completes at once with result 0. So does a reset release while none is held.
- R12: Requests that arrive while busy are ignored. Simultaneous requests are served in the order take > release > reset assert > reset release. The result code changes only together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_take | input | 1 | Take-ownership request pulse |
| req_give | input | 1 | Release-ownership request pulse |
| req_rst_on | input | 1 | Reset assert request pulse |
| req_rst_off | input | 1 | Reset release request pulse |
| mode_wide | input | 1 | Requested width: 1 = 32 bits, 0 = 16 bits |
| mode_crypt | input | 1 | Requested mode has encryption |
| mode_comp | input | 1 | Requested mode has compression |
| strap_sel | input | 3 | Mode-select strap levels |
| pin_ncfg_lvl | input | 1 | External nCONFIG pin level |
| pin_nstat_lvl | input | 1 | External nSTATUS pin level |
| cfg_nce_o | output | 1 | Chip enable drive, active low |
| cfg_ncfg_o | output | 1 | nCONFIG drive level |
| ovr_datclk_o | output | 1 | Data and clock override enable |
| ovr_ncfg_o | output | 1 | nCONFIG override enable |
| ovr_sense_o | output | 1 | nSTATUS / CONF_DONE override enable (kept off) |
| path_data_en_o | output | 1 | Data path enable |
| path_clk_en_o | output | 1 | Configuration clock path enable |
| width32_o | output | 1 | Width field: 1 = 32 bits |
| ratio_code_o | output | 2 | log2 of clock-to-data ratio |
| owned_o | output | 1 | Port is held by the host |
| busy_o | output | 1 | A multi-cycle request is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 3 | Result code: 0 ok, 1 strap, 2 pin pre-check, 3 pin recheck, 4 not owned, 5 timeout |

## Verification
A wrong ownership or reset-held flag shows at the next request. A repeated reset request or a take request would then complete at once instead of driving nCONFIG, or the reverse, and the done latency and result code show this within two cycles. A step order that is wrong shows as an override rising while chip enable is low, or as chip enable falling before the overrides are on, on the very cycle it happens. Poll counting that is wrong shows as a timeout done arriving at a cycle other than POLL_LIMIT+1 after the request.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int RATIO_W = 2;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_STRAP    = 3'd1,
    ERR_PIN_PRE  = 3'd2,
    ERR_PIN_POST = 3'd3,
    ERR_NOCTRL   = 3'd4,
    ERR_TIMEOUT  = 3'd5
  } err_e;

  typedef enum logic [2:0] {
    REQ_NONE,
    REQ_TAKE,
    REQ_GIVE,
    REQ_RST_ON,
    REQ_RST_OFF
  } req_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_EN_CHK,
    S_EN_SAFE,
    S_EN_OVR,
    S_EN_CS,
    S_EN_RECHK,
    S_DIS_NCFG,
    S_DIS_CS,
    S_DIS_OVR,
    S_WAIT_LO,
    S_WAIT_HI
  } state_e;

  // log2 of the clock-to-data ratio for a requested mode
  function automatic logic [RATIO_W-1:0] ratio_code(input logic wide,
                                                    input logic crypt,
                                                    input logic comp);
    logic [RATIO_W-1:0] r;
    if (comp)       r = wide ? 2'd3 : 2'd2;
    else if (crypt) r = wide ? 2'd2 : 2'd1;
    else            r = 2'd0;
    return r;
  endfunction

  // strap is acceptable when every bit above bit 0 is clear
  function automatic logic strap_ok(input logic [2:0] sel);
    return (sel[2:1] == 2'b00);
  endfunction
endpackage

// File: rtl/cfgport_req_arb.sv
module cfgport_req_arb
  import cfgport_pkg::*;
(
  input  logic idle,
  input  logic take,
  input  logic give,
  input  logic rst_on,
  input  logic rst_off,
  output req_e kind
);
  always_comb begin
    kind = REQ_NONE;
    if (idle) begin
      if (take)         kind = REQ_TAKE;
      else if (give)    kind = REQ_GIVE;
      else if (rst_on)  kind = REQ_RST_ON;
      else if (rst_off) kind = REQ_RST_OFF;
    end
  end
endmodule

// File: rtl/cfgport_mode_map.sv
module cfgport_mode_map
  import cfgport_pkg::*;
(
  input  logic               wide,
  input  logic               crypt,
  input  logic               comp,
  output logic               w32,
  output logic [RATIO_W-1:0] ratio
);
  assign w32   = wide;
  assign ratio = ratio_code(wide, crypt, comp);
endmodule

// File: rtl/cfgport_poll_timer.sv
module cfgport_poll_timer #(
  parameter int POLL_LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(POLL_LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);
endmodule

// File: rtl/cfgport_seq.sv
module cfgport_seq
  import cfgport_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  req_e               kind,
  input  logic               map_w32,
  input  logic [RATIO_W-1:0] map_ratio,
  input  logic               strap_good,
  input  logic               pins_high,
  input  logic               nstat_lvl,
  input  logic               tmr_exp,
  output logic               tmr_run,
  output logic               idle,
  output logic               nce,
  output logic               ncfg,
  output logic               ovr_dc,
  output logic               ovr_nc,
  output logic               ovr_sense,
  output logic               den,
  output logic               cen,
  output logic               w32,
  output logic [RATIO_W-1:0] ratio,
  output logic               owned,
  output logic               done,
  output err_e               err
);
  state_e             state;
  logic               rst_held;
  logic               pend_w32;
  logic [RATIO_W-1:0] pend_ratio;

  assign idle    = (state == S_IDLE);
  assign tmr_run = (state == S_WAIT_LO) || (state == S_WAIT_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      rst_held   <= 1'b0;
      pend_w32   <= 1'b0;
      pend_ratio <= '0;
      nce        <= 1'b1;
      ncfg       <= 1'b1;
      ovr_dc     <= 1'b0;
      ovr_nc     <= 1'b0;
      ovr_sense  <= 1'b0;
      den        <= 1'b0;
      cen        <= 1'b0;
      w32        <= 1'b0;
      ratio      <= '0;
      owned      <= 1'b0;
      done       <= 1'b0;
      err        <= ERR_NONE;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          unique case (kind)
            REQ_TAKE: begin
              if (owned) begin
                done <= 1'b1;
                err  <= ERR_NONE;
              end else begin
                pend_w32   <= map_w32;
                pend_ratio <= map_ratio;
                state      <= S_EN_CHK;
              end
            end
            REQ_GIVE: begin
              if (!owned) begin
                done <= 1'b1;
                err  <= ERR_NONE;
              end else begin
                owned <= 1'b0;
                state <= rst_held ? S_DIS_NCFG : S_DIS_CS;
              end
            end
            REQ_RST_ON: begin
              if (!owned) begin
                done <= 1'b1;
                err  <= ERR_NOCTRL;
              end else if (rst_held) begin
                done <= 1'b1;
                err  <= ERR_NONE;
              end else begin
                ncfg     <= 1'b0;
                rst_held <= 1'b1;
                state    <= S_WAIT_LO;
              end
            end
            REQ_RST_OFF: begin
              if (!owned) begin
                done <= 1'b1;
                err  <= ERR_NOCTRL;
              end else if (!rst_held) begin
                done <= 1'b1;
                err  <= ERR_NONE;
              end else begin
                ncfg     <= 1'b1;
                rst_held <= 1'b0;
                state    <= S_WAIT_HI;
              end
            end
            default: ;
          endcase
        end
        S_EN_CHK: begin
          if (!strap_good) begin
            done  <= 1'b1;
            err   <= ERR_STRAP;
            state <= S_IDLE;
          end else begin
            w32   <= pend_w32;
            ratio <= pend_ratio;
            if (!pins_high) begin
              done  <= 1'b1;
              err   <= ERR_PIN_PRE;
              state <= S_IDLE;
            end else begin
              state <= S_EN_SAFE;
            end
          end
        end
        S_EN_SAFE: begin
          nce       <= 1'b1;
          ncfg      <= 1'b1;
          den       <= 1'b0;
          cen       <= 1'b0;
          ovr_sense <= 1'b0;
          state     <= S_EN_OVR;
        end
        S_EN_OVR: begin
          ovr_dc    <= 1'b1;
          ovr_nc    <= 1'b1;
          ovr_sense <= 1'b0;
          state     <= S_EN_CS;
        end
        S_EN_CS: begin
          nce   <= 1'b0;
          state <= S_EN_RECHK;
        end
        S_EN_RECHK: begin
          done  <= 1'b1;
          state <= S_IDLE;
          if (pins_high) begin
            owned <= 1'b1;
            err   <= ERR_NONE;
          end else begin
            nce    <= 1'b1;
            ovr_dc <= 1'b0;
            ovr_nc <= 1'b0;
            err    <= ERR_PIN_POST;
          end
        end
        S_DIS_NCFG: begin
          ncfg     <= 1'b1;
          rst_held <= 1'b0;
          state    <= S_DIS_CS;
        end
        S_DIS_CS: begin
          nce   <= 1'b1;
          state <= S_DIS_OVR;
        end
        S_DIS_OVR: begin
          ovr_dc <= 1'b0;
          ovr_nc <= 1'b0;
          done   <= 1'b1;
          err    <= ERR_NONE;
          state  <= S_IDLE;
        end
        S_WAIT_LO: begin
          if (!nstat_lvl) begin
            done  <= 1'b1;
            err   <= ERR_NONE;
            state <= S_IDLE;
          end else if (tmr_exp) begin
            done  <= 1'b1;
            err   <= ERR_TIMEOUT;
            state <= S_IDLE;
          end
        end
        S_WAIT_HI: begin
          if (nstat_lvl) begin
            done  <= 1'b1;
            err   <= ERR_NONE;
            state <= S_IDLE;
          end else if (tmr_exp) begin
            done  <= 1'b1;
            err   <= ERR_TIMEOUT;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfgport_owner_ctrl.sv
module cfgport_owner_ctrl
  import cfgport_pkg::*;
#(
  parameter int POLL_LIMIT = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_take,
  input  logic       req_give,
  input  logic       req_rst_on,
  input  logic       req_rst_off,
  input  logic       mode_wide,
  input  logic       mode_crypt,
  input  logic       mode_comp,
  input  logic [2:0] strap_sel,
  input  logic       pin_ncfg_lvl,
  input  logic       pin_nstat_lvl,
  output logic       cfg_nce_o,
  output logic       cfg_ncfg_o,
  output logic       ovr_datclk_o,
  output logic       ovr_ncfg_o,
  output logic       ovr_sense_o,
  output logic       path_data_en_o,
  output logic       path_clk_en_o,
  output logic       width32_o,
  output logic [1:0] ratio_code_o,
  output logic       owned_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [2:0] err_o
);
  // internal events, named for the bound checker
  req_e               req_kind;
  logic               seq_idle;
  logic               tmr_run;
  logic               tmr_exp;
  logic               map_w32;
  logic [RATIO_W-1:0] map_ratio;
  logic               strap_good;
  logic               pins_high;
  err_e               err_q;

  assign strap_good = strap_ok(strap_sel);
  assign pins_high  = pin_ncfg_lvl && pin_nstat_lvl;

  cfgport_req_arb u_arb (
    .idle    (seq_idle),
    .take    (req_take),
    .give    (req_give),
    .rst_on  (req_rst_on),
    .rst_off (req_rst_off),
    .kind    (req_kind)
  );

  cfgport_mode_map u_map (
    .wide  (mode_wide),
    .crypt (mode_crypt),
    .comp  (mode_comp),
    .w32   (map_w32),
    .ratio (map_ratio)
  );

  cfgport_poll_timer #(.POLL_LIMIT(POLL_LIMIT)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (tmr_run),
    .expired (tmr_exp)
  );

  cfgport_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .kind       (req_kind),
    .map_w32    (map_w32),
    .map_ratio  (map_ratio),
    .strap_good (strap_good),
    .pins_high  (pins_high),
    .nstat_lvl  (pin_nstat_lvl),
    .tmr_exp    (tmr_exp),
    .tmr_run    (tmr_run),
    .idle       (seq_idle),
    .nce        (cfg_nce_o),
    .ncfg       (cfg_ncfg_o),
    .ovr_dc     (ovr_datclk_o),
    .ovr_nc     (ovr_ncfg_o),
    .ovr_sense  (ovr_sense_o),
    .den        (path_data_en_o),
    .cen        (path_clk_en_o),
    .w32        (width32_o),
    .ratio      (ratio_code_o),
    .owned      (owned_o),
    .done       (done_o),
    .err        (err_q)
  );

  assign busy_o = !seq_idle;
  assign err_o  = err_q;
endmodule

// File: rtl/cfgport_owner_chk.sv
module cfgport_owner_chk #(
  parameter int POLL_LIMIT = 1000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_nce_o,
  input logic       cfg_ncfg_o,
  input logic       ovr_datclk_o,
  input logic       ovr_ncfg_o,
  input logic       ovr_sense_o,
  input logic       path_data_en_o,
  input logic       path_clk_en_o,
  input logic       width32_o,
  input logic [1:0] ratio_code_o,
  input logic       owned_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [2:0] err_o
);
  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_run <= 0;
    else if (busy_o) busy_run <= busy_run + 1;
    else             busy_run <= 0;
  end

  // R5
  takeover_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_ncfg_o) |-> cfg_nce_o && cfg_ncfg_o && !path_data_en_o && !path_clk_en_o);

  // R5
  cs_after_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_nce_o) |-> ovr_datclk_o && ovr_ncfg_o && !ovr_sense_o);

  // R5
  owned_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owned_o |-> !cfg_nce_o && ovr_datclk_o && ovr_ncfg_o && !ovr_sense_o);

  // R5
  takeover_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(owned_o) |-> done_o && (err_o == 3'd0));

  // R8
  release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_ncfg_o) |-> cfg_nce_o && cfg_ncfg_o);

  // R10
  ncfg_unowned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!owned_o && !busy_o) |-> cfg_ncfg_o);

  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owned_o && $past(owned_o)) |-> ($stable(width32_o) && $stable(ratio_code_o)));

  // R12
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && busy_o));

  // R12
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(err_o));

  // R9
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= POLL_LIMIT + 4);
endmodule

bind cfgport_owner_ctrl cfgport_owner_chk #(.POLL_LIMIT(POLL_LIMIT)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_nce_o      (cfg_nce_o),
  .cfg_ncfg_o     (cfg_ncfg_o),
  .ovr_datclk_o   (ovr_datclk_o),
  .ovr_ncfg_o     (ovr_ncfg_o),
  .ovr_sense_o    (ovr_sense_o),
  .path_data_en_o (path_data_en_o),
  .path_clk_en_o  (path_clk_en_o),
  .width32_o      (width32_o),
  .ratio_code_o   (ratio_code_o),
  .owned_o        (owned_o),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .err_o          (err_o)
);

// File: tb/tb_cfgport_owner_ctrl.sv
`timescale 1ns/1ps
module tb_cfgport_owner_ctrl;
  localparam int PL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_take = 0, req_give = 0, req_rst_on = 0, req_rst_off = 0;
  logic mode_wide = 0, mode_crypt = 0, mode_comp = 0;
  logic [2:0] strap_sel = 3'd0;
  logic pin_ncfg_lvl = 1'b1;
  logic nstat_hold = 1'b1;
  logic follow = 1'b0;
  logic pin_nstat_lvl;

  logic cfg_nce_o, cfg_ncfg_o, ovr_datclk_o, ovr_ncfg_o, ovr_sense_o;
  logic path_data_en_o, path_clk_en_o, width32_o, owned_o, busy_o, done_o;
  logic [1:0] ratio_code_o;
  logic [2:0] err_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // nSTATUS either tracks the driven nCONFIG level or is held by the bench
  assign pin_nstat_lvl = follow ? cfg_ncfg_o : nstat_hold;

  always #2 clk = ~clk;

  cfgport_owner_ctrl #(.POLL_LIMIT(PL)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_take(req_take), .req_give(req_give),
    .req_rst_on(req_rst_on), .req_rst_off(req_rst_off),
    .mode_wide(mode_wide), .mode_crypt(mode_crypt), .mode_comp(mode_comp),
    .strap_sel(strap_sel), .pin_ncfg_lvl(pin_ncfg_lvl), .pin_nstat_lvl(pin_nstat_lvl),
    .cfg_nce_o(cfg_nce_o), .cfg_ncfg_o(cfg_ncfg_o),
    .ovr_datclk_o(ovr_datclk_o), .ovr_ncfg_o(ovr_ncfg_o), .ovr_sense_o(ovr_sense_o),
    .path_data_en_o(path_data_en_o), .path_clk_en_o(path_clk_en_o),
    .width32_o(width32_o), .ratio_code_o(ratio_code_o),
    .owned_o(owned_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // v = {rst_off, rst_on, give, take}; cyc = sampling cycles until done
  task automatic pulse(input logic [3:0] v, output int cyc);
    @(negedge clk);
    {req_rst_off, req_rst_on, req_give, req_take} = v;
    @(negedge clk);
    {req_rst_off, req_rst_on, req_give, req_take} = 4'b0;
    cyc = 1;
    while (!done_o && cyc < 64) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  function automatic int exp_ratio(input logic w, input logic cr, input logic cp);
    int mult;
    mult = cp ? (w ? 8 : 4) : (cr ? (w ? 4 : 2) : 1);
    return $clog2(mult);
  endfunction

  task automatic port_released(input string tag);
    chk(tag, "nce high", int'(cfg_nce_o), 1);
    chk(tag, "ovr datclk off", int'(ovr_datclk_o), 0);
    chk(tag, "ovr ncfg off", int'(ovr_ncfg_o), 0);
    chk(tag, "owned", int'(owned_o), 0);
  endtask

  task automatic take_ok(input string tag);
    int c;
    pulse(4'b0001, c);
    chk(tag, "take latency", c, 6);
    chk(tag, "take result", int'(err_o), 0);
    chk(tag, "owned", int'(owned_o), 1);
  endtask

  task automatic give_ok(input string tag, input int lat);
    int c;
    pulse(4'b0010, c);
    chk(tag, "give latency", c, lat);
    chk(tag, "give result", int'(err_o), 0);
    port_released(tag);
    chk(tag, "ncfg high", int'(cfg_ncfg_o), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "nce", int'(cfg_nce_o), 1);
    chk("R1", "ncfg", int'(cfg_ncfg_o), 1);
    chk("R1", "overrides", int'({ovr_datclk_o, ovr_ncfg_o, ovr_sense_o}), 0);
    chk("R1", "paths", int'({path_data_en_o, path_clk_en_o}), 0);
    chk("R1", "width/ratio", int'({width32_o, ratio_code_o}), 0);
    chk("R1", "owned/busy/done", int'({owned_o, busy_o, done_o}), 0);
    chk("R1", "result", int'(err_o), 0);

    // R2 strap sweep
    for (int s = 0; s < 8; s++) begin
      strap_sel = 3'(s);
      if (s <= 1) begin
        take_ok("R2");
        give_ok("R8", 3);
      end else begin
        pulse(4'b0001, c);
        chk("R2", "bad strap latency", c, 2);
        chk("R2", "bad strap result", int'(err_o), 1);
        port_released("R2");
      end
    end
    strap_sel = 3'd0;

    // R3 pin pre-check
    for (int p = 0; p < 3; p++) begin
      pin_ncfg_lvl = p[0];
      nstat_hold   = p[1];
      pulse(4'b0001, c);
      chk("R3", "pin result", int'(err_o), 2);
      port_released("R3");
    end
    pin_ncfg_lvl = 1'b1;
    nstat_hold   = 1'b1;

    // R4/R5 mode sweep with full takeover and release
    for (int m = 0; m < 8; m++) begin
      {mode_wide, mode_crypt, mode_comp} = 3'(m);
      take_ok("R5");
      chk("R4", "width", int'(width32_o), int'(mode_wide));
      chk("R4", "ratio", int'(ratio_code_o), exp_ratio(mode_wide, mode_crypt, mode_comp));
      chk("R5", "nce low", int'(cfg_nce_o), 0);
      chk("R5", "overrides", int'({ovr_datclk_o, ovr_ncfg_o, ovr_sense_o}), 3'b110);
      chk("R5", "paths off", int'({path_data_en_o, path_clk_en_o}), 0);
      give_ok("R8", 3);
    end

    // R6 pin drops between the first check and the recheck
    {mode_wide, mode_crypt, mode_comp} = 3'b000;
    @(negedge clk); req_take = 1'b1;
    @(negedge clk); req_take = 1'b0;
    @(negedge clk); nstat_hold = 1'b0;
    c = 0;
    while (!done_o && c < 64) begin @(negedge clk); c++; end
    chk("R6", "recheck result", int'(err_o), 3);
    port_released("R6");
    nstat_hold = 1'b1;

    // R7 take while owned, different mode
    {mode_wide, mode_crypt, mode_comp} = 3'b010;
    take_ok("R7");
    {mode_wide, mode_crypt, mode_comp} = 3'b101;
    pulse(4'b0001, c);
    chk("R7", "latency", c, 1);
    chk("R7", "result", int'(err_o), 0);
    chk("R7", "ratio kept", int'(ratio_code_o), 1);
    chk("R7", "width kept", int'(width32_o), 0);

    // R9 / R11 reset with a responding nSTATUS
    follow = 1'b1;
    pulse(4'b0100, c);
    chk("R9", "assert latency", c, 2);
    chk("R9", "assert result", int'(err_o), 0);
    chk("R9", "ncfg low", int'(cfg_ncfg_o), 0);
    pulse(4'b0100, c);
    chk("R11", "repeat assert latency", c, 1);
    chk("R11", "repeat assert result", int'(err_o), 0);
    pulse(4'b1000, c);
    chk("R9", "release latency", c, 2);
    chk("R9", "ncfg high", int'(cfg_ncfg_o), 1);
    pulse(4'b1000, c);
    chk("R11", "repeat release latency", c, 1);
    chk("R11", "repeat release result", int'(err_o), 0);

    // R9 timeout: nSTATUS stuck high
    follow = 1'b0;
    nstat_hold = 1'b1;
    pulse(4'b0100, c);
    chk("R9", "timeout latency", c, PL + 1);
    chk("R9", "timeout result", int'(err_o), 5);
    chk("R9", "ncfg kept low", int'(cfg_ncfg_o), 0);
    // R8 release with reset held
    give_ok("R8", 4);
    pulse(4'b0010, c);
    chk("R8", "give unowned latency", c, 1);
    chk("R8", "give unowned result", int'(err_o), 0);

    // R10 reset requests while not owned
    pulse(4'b0100, c);
    chk("R10", "assert result", int'(err_o), 4);
    chk("R10", "ncfg high", int'(cfg_ncfg_o), 1);
    pulse(4'b1000, c);
    chk("R10", "release result", int'(err_o), 4);

    // R12 request during busy is ignored
    @(negedge clk); req_take = 1'b1;
    @(negedge clk); req_take = 1'b0;
    @(negedge clk); req_give = 1'b1;
    @(negedge clk); req_give = 1'b0;
    c = 0;
    while (!done_o && c < 64) begin @(negedge clk); c++; end
    chk("R12", "owned after ignored give", int'(owned_o), 1);
    repeat (4) @(negedge clk);
    chk("R12", "no extra done", int'(done_o), 0);
    chk("R12", "still owned", int'(owned_o), 1);
    // R12 priority: take over give, take over reset assert
    pulse(4'b0011, c);
    chk("R12", "take beats give latency", c, 1);
    chk("R12", "owned kept", int'(owned_o), 1);
    pulse(4'b0101, c);
    chk("R12", "take beats assert", int'(cfg_ncfg_o), 1);
    pulse(4'b0110, c);
    chk("R12", "give beats assert latency", c, 3);
    chk("R12", "give beats assert ncfg", int'(cfg_ncfg_o), 1);
    chk("R12", "give beats assert owned", int'(owned_o), 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule